// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 64 interrupt request inputs into two 32-bit banks and drives two outputs: a normal interrupt line and a fast interrupt line. Software configures each source through a small register bus. The configuration covers whether the source is enabled, whether a software trigger is pending, which output it is routed to, whether it is level or edge sensitive, and which level or edge counts as active. Edge-sensitive sources capture their edge in a latch that stays set until software clears it.

Every register exists once per bank. The two bank words of one register sit at adjacent word addresses, so the register index is taken from the upper address bits and the bank from address bit 2. Enable and software trigger each have a write-one-to-set address and a write-one-to-clear address. Reads are combinational and have no side effects. The outputs are combinational functions of the held state and the live request inputs.

Top module: `irqc_dual_bank`

## Requirements
- R1: A 1 written to a bit at the enable-set index (4) enables that source, and a 1 at the enable-clear index (5) disables it. Bits written as 0 leave the enable unchanged.
- R2: The software trigger has the same write-one set and clear behaviour at index 6 (set) and index 7 (clear). A set trigger bit makes its source active in raw status.
- R3: The route register (index 3) sends a source to the normal output when its bit is 0 and to the fast output when its bit is 1.
- R4: A source whose sense bit (index 8) is 1 is level sensitive. It is active while its input equals its polarity bit (index 10): 1 means active high, 0 means active low.
- R5: A source whose sense bit is 0 is edge sensitive. The input is compared against its registered value from the previous cycle, and a detected edge sets the source's latch at that clock edge. With the both-edges bit (index 9) set, either transition is detected. Otherwise polarity 1 selects rising edges and polarity 0 selects falling edges.
- R6: A 1 written at the latch-clear index (11) clears that source's edge latch. An edge detected in the same cycle wins and keeps the latch set. Level sources never hold a latch. Latch state reads at index 12.
- R7: Raw status (index 2) is the active level OR the edge latch OR the software trigger. Normal status (index 0) is raw AND enable AND NOT route. Fast status (index 1) is raw AND enable AND route. Each output line is the OR of its status across all 64 sources.
- R8: Byte address = index*8 + bank*4. Bank 0 holds sources 0 to 31, and bank 1 holds sources 32 to 63 at bit n-32.
- R9: Synchronous active-low reset clears every register. The exceptions are sense and polarity, which load parameter values (defaults: sense 0xFFFF0000FFFF0000, polarity all ones). Both outputs are low after reset.
- R10: Addresses are unmapped when bits [1:0] are nonzero or the index is above 12. Unmapped addresses read as zero, and writes to them are ignored. Writes to the status indices 0, 1, 2 and 12 are also ignored.
- R11: Reading a set or clear address returns the register it controls: enable at 4 and 5, trigger at 6 and 7, and latch state at 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Interrupt request inputs |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The assertions assume that the request inputs and the bus signals change only between clock edges and are held steady across each rising edge. They also assume that rst_n is held low for at least one edge before the first bus access. The bench meets both conditions by driving every input shortly after the falling edge. It keeps src_i low during reset and issues at most one bus operation per cycle. Random register writes, sparse random input toggles and occasional unmapped or status-address writes are mixed in without breaking those conditions.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg: register indices and write strobes shared by the
// controller modules. Indices are the byte address shifted past the bank bit.
package irqc_pkg;

    localparam int WORD_W  = 32;
    localparam int IDX_MAX = 12;

    typedef enum logic [4:0] {
        RG_IRQ_ST    = 5'd0,
        RG_FIQ_ST    = 5'd1,
        RG_RAW       = 5'd2,
        RG_ROUTE     = 5'd3,
        RG_EN_SET    = 5'd4,
        RG_EN_CLR    = 5'd5,
        RG_SW_SET    = 5'd6,
        RG_SW_CLR    = 5'd7,
        RG_SENSE     = 5'd8,
        RG_BOTH      = 5'd9,
        RG_POL       = 5'd10,
        RG_LATCH_CLR = 5'd11,
        RG_LATCH_ST  = 5'd12
    } reg_idx_e;

    typedef struct packed {
        logic route;
        logic en_set;
        logic en_clr;
        logic sw_set;
        logic sw_clr;
        logic sense;
        logic both;
        logic pol;
        logic latch_clr;
    } wr_strb_t;

endpackage

// File: rtl/irqc_decode.sv
// Module irqc_decode: splits a byte address into a register index and a
// bank number, flags unmapped addresses, and produces one write strobe per
// writable register. Assumes NUM_BANKS is a power of two, at least 2.
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         we,
    output logic                         mapped,
    output reg_idx_e                     idx,
    output logic [$clog2(NUM_BANKS)-1:0] bank,
    output wr_strb_t                     strb
);
    localparam int BANK_BITS = $clog2(NUM_BANKS);
    localparam int IDX_LSB   = 2 + BANK_BITS;
    localparam int IDX_BITS  = ADDR_W - IDX_LSB;

    logic [IDX_BITS-1:0] raw_idx;
    logic                wr_ok;

    // Field extraction and the mapped/unmapped decision.
    always_comb begin
        raw_idx = addr[ADDR_W-1:IDX_LSB];
        bank    = addr[IDX_LSB-1:2];
        mapped  = (addr[1:0] == 2'b00) && (int'(raw_idx) <= IDX_MAX);
        idx     = mapped ? reg_idx_e'(raw_idx[4:0]) : RG_IRQ_ST;
        wr_ok   = we && mapped;
    end

    // One strobe per writable register; status indices produce none.
    always_comb begin
        strb           = '0;
        strb.route     = wr_ok && (idx == RG_ROUTE);
        strb.en_set    = wr_ok && (idx == RG_EN_SET);
        strb.en_clr    = wr_ok && (idx == RG_EN_CLR);
        strb.sw_set    = wr_ok && (idx == RG_SW_SET);
        strb.sw_clr    = wr_ok && (idx == RG_SW_CLR);
        strb.sense     = wr_ok && (idx == RG_SENSE);
        strb.both      = wr_ok && (idx == RG_BOTH);
        strb.pol       = wr_ok && (idx == RG_POL);
        strb.latch_clr = wr_ok && (idx == RG_LATCH_CLR);
    end

endmodule

// File: rtl/irqc_edge.sv
// Module irqc_edge: per-bit edge detector and edge latch for one bank, plus
// the active-level term for level sources. Assumes inputs are already
// synchronous to clk. A clear and a new edge in the same cycle keep the latch.
module irqc_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] both,
    input  logic [W-1:0] pol,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] latch,
    output logic [W-1:0] level_act
);
    logic [W-1:0] prev;
    logic [W-1:0] hit;
    logic [W-1:0] clr_bits;

    // Edge detection against last cycle's input, chosen per bit.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (sense[i])
                hit[i] = 1'b0;
            else if (both[i])
                hit[i] = src[i] ^ prev[i];
            else if (pol[i])
                hit[i] = src[i] & ~prev[i];
            else
                hit[i] = ~src[i] & prev[i];
        end
        clr_bits  = clr_we ? clr_mask : '0;
        level_act = sense & ~(src ^ pol);
    end

    // Input history register.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= src;
    end

    // Edge latch: set on edge, cleared by software, never held for level.
    always_ff @(posedge clk) begin
        if (!rst_n) latch <= '0;
        else        latch <= ((latch & ~clr_bits) | hit) & ~sense;
    end

    AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((latch & $past(clr_mask) & ~$past(hit)) == '0)); // R6
    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> (((latch | sense) & $past(hit)) == $past(hit))); // R5

endmodule

// File: rtl/irqc_bank.sv
// Module irqc_bank: the configuration registers, edge logic and status words
// of one 32-source bank, with its own read mux. Write strobes arrive already
// qualified by the bank select.
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int           W          = 32,
    parameter logic [W-1:0] SENSE_INIT = '0,
    parameter logic [W-1:0] POL_INIT   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_strb_t     strb,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] src,
    input  reg_idx_e     rd_idx,
    output logic [W-1:0] rdata,
    output logic [W-1:0] enable,
    output logic [W-1:0] irq_st,
    output logic [W-1:0] fiq_st
);
    logic [W-1:0] route;
    logic [W-1:0] sw_trig;
    logic [W-1:0] sense;
    logic [W-1:0] both;
    logic [W-1:0] pol;
    logic [W-1:0] latch;
    logic [W-1:0] level_act;
    logic [W-1:0] raw;

    // Enable: write-one-to-set and write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           enable <= '0;
        else if (strb.en_set) enable <= enable | wdata;
        else if (strb.en_clr) enable <= enable & ~wdata;
    end

    // Software trigger: write-one-to-set and write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           sw_trig <= '0;
        else if (strb.sw_set) sw_trig <= sw_trig | wdata;
        else if (strb.sw_clr) sw_trig <= sw_trig & ~wdata;
    end

    // Plain configuration registers: route, sense, both-edges, polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route <= '0;
            sense <= SENSE_INIT;
            both  <= '0;
            pol   <= POL_INIT;
        end else begin
            if (strb.route) route <= wdata;
            if (strb.sense) sense <= wdata;
            if (strb.both)  both  <= wdata;
            if (strb.pol)   pol   <= wdata;
        end
    end

    irqc_edge #(.W(W)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src),
        .sense     (sense),
        .both      (both),
        .pol       (pol),
        .clr_we    (strb.latch_clr),
        .clr_mask  (wdata),
        .latch     (latch),
        .level_act (level_act)
    );

    // Status words for the two outputs.
    always_comb begin
        raw    = level_act | latch | sw_trig;
        irq_st = raw & enable & ~route;
        fiq_st = raw & enable & route;
    end

    // Register read mux; set and clear addresses read their target.
    always_comb begin
        unique case (rd_idx)
            RG_IRQ_ST:                 rdata = irq_st;
            RG_FIQ_ST:                 rdata = fiq_st;
            RG_RAW:                    rdata = raw;
            RG_ROUTE:                  rdata = route;
            RG_EN_SET, RG_EN_CLR:      rdata = enable;
            RG_SW_SET, RG_SW_CLR:      rdata = sw_trig;
            RG_SENSE:                  rdata = sense;
            RG_BOTH:                   rdata = both;
            RG_POL:                    rdata = pol;
            RG_LATCH_CLR, RG_LATCH_ST: rdata = latch;
            default:                   rdata = '0;
        endcase
    end

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        strb.en_set |=> ((enable & $past(wdata)) == $past(wdata))); // R1
    AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        strb.en_clr |=> ((enable & $past(wdata)) == '0)); // R1
    AST_TRIGGER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        strb.sw_set |=> ((sw_trig & $past(wdata)) == $past(wdata))); // R2
    AST_TRIGGER_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & sw_trig) == sw_trig)); // R2

endmodule

// File: rtl/irqc_dual_bank.sv
// Module irqc_dual_bank: top of the interrupt controller. Decodes the bus,
// instantiates one bank per 32 sources, merges read data and reduces the
// status words to the two interrupt lines. Assumes one access per cycle.
module irqc_dual_bank
    import irqc_pkg::*;
#(
    parameter int                 NUM_SRC   = 64,
    parameter int                 ADDR_W    = 8,
    parameter logic [NUM_SRC-1:0] SENSE_RST = 64'hFFFF_0000_FFFF_0000,
    parameter logic [NUM_SRC-1:0] POL_RST   = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int NUM_BANKS = NUM_SRC / WORD_W;
    localparam int BANK_BITS = $clog2(NUM_BANKS);

    logic                 mapped;
    reg_idx_e             idx;
    logic [BANK_BITS-1:0] bank;
    wr_strb_t             strb;
    logic [WORD_W-1:0]    rd_w   [NUM_BANKS];
    logic [WORD_W-1:0]    en_w   [NUM_BANKS];
    logic [WORD_W-1:0]    irq_w  [NUM_BANKS];
    logic [WORD_W-1:0]    fiq_w  [NUM_BANKS];
    logic                 any_en;

    irqc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr   (bus_addr),
        .we     (bus_we),
        .mapped (mapped),
        .idx    (idx),
        .bank   (bank),
        .strb   (strb)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        wr_strb_t bank_strb;

        // Qualify the shared strobes with this bank's select.
        always_comb bank_strb = (int'(bank) == b) ? strb : '0;

        irqc_bank #(
            .W          (WORD_W),
            .SENSE_INIT (SENSE_RST[b*WORD_W +: WORD_W]),
            .POL_INIT   (POL_RST[b*WORD_W +: WORD_W])
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .strb   (bank_strb),
            .wdata  (bus_wdata),
            .src    (src_i[b*WORD_W +: WORD_W]),
            .rd_idx (idx),
            .rdata  (rd_w[b]),
            .enable (en_w[b]),
            .irq_st (irq_w[b]),
            .fiq_st (fiq_w[b])
        );
    end

    // Read data selection and output reduction across banks.
    always_comb begin
        bus_rdata = mapped ? rd_w[bank] : '0;
        irq_o     = 1'b0;
        fiq_o     = 1'b0;
        any_en    = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            irq_o  = irq_o  | (|irq_w[b]);
            fiq_o  = fiq_o  | (|fiq_w[b]);
            any_en = any_en | (|en_w[b]);
        end
    end

    AST_OUT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> any_en); // R7
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_o && !fiq_o)); // R9

endmodule

// File: tb/irqc_dual_bank_test.sv
module irqc_dual_bank_test;

    localparam logic [63:0] SENSE_RST = 64'hFFFF_0000_FFFF_0000;
    localparam logic [63:0] POL_RST   = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    irqc_dual_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    always #2 clk = ~clk;

    // Reference model state
    logic [63:0] m_en, m_sw, m_route, m_sense, m_both, m_pol, m_latch, m_prev;

    function automatic logic [63:0] m_raw();
        return (m_sense & ~(src_i ^ m_pol)) | m_latch | m_sw;
    endfunction

    function automatic logic [63:0] wmask(input logic [7:0] a, input logic [31:0] d);
        return a[2] ? {d, 32'h0} : {32'h0, d};
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [63:0] v;
        int idx = int'(a[7:3]);
        if (a[1:0] != 2'b00 || idx > 12) return 32'h0;
        case (idx)
            0:      v = m_raw() & m_en & ~m_route;
            1:      v = m_raw() & m_en & m_route;
            2:      v = m_raw();
            3:      v = m_route;
            4, 5:   v = m_en;
            6, 7:   v = m_sw;
            8:      v = m_sense;
            9:      v = m_both;
            10:     v = m_pol;
            default: v = m_latch;
        endcase
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        int idx = int'(a[7:3]);
        string t;
        if (a[1:0] != 2'b00 || idx > 12) return "R10";
        case (idx)
            0, 1, 2: t = "R7";
            3:       t = "R3";
            4, 5:    t = "R1 R11";
            6, 7:    t = "R2 R11";
            8:       t = "R4";
            9, 10:   t = "R5";
            default: t = "R6";
        endcase
        if (a[2]) t = {t, " R8"};
        return t;
    endfunction

    // Model update at each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_sw = '0; m_route = '0; m_both = '0; m_latch = '0; m_prev = '0;
            m_sense = SENSE_RST; m_pol = POL_RST;
        end else begin
            logic [63:0] hit, clr, wm, nl;
            int idx;
            hit = ~m_sense & ((m_both & (src_i ^ m_prev)) |
                  (~m_both & m_pol & src_i & ~m_prev) |
                  (~m_both & ~m_pol & ~src_i & m_prev));
            wm  = wmask(bus_addr, bus_wdata);
            idx = int'(bus_addr[7:3]);
            clr = '0;
            if (bus_we && bus_addr[1:0] == 2'b00 && idx == 11) clr = wm;
            nl = ((m_latch & ~clr) | hit) & ~m_sense;
            if (bus_we && bus_addr[1:0] == 2'b00) begin
                logic [63:0] keep;
                keep = bus_addr[2] ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_0000_0000;
                case (idx)
                    3:  m_route = (m_route & keep) | wm;
                    4:  m_en    = m_en | wm;
                    5:  m_en    = m_en & ~wm;
                    6:  m_sw    = m_sw | wm;
                    7:  m_sw    = m_sw & ~wm;
                    8:  m_sense = (m_sense & keep) | wm;
                    9:  m_both  = (m_both & keep) | wm;
                    10: m_pol   = (m_pol & keep) | wm;
                    default: ;
                endcase
            end
            m_latch = nl;
            m_prev  = src_i;
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [63:0] r = m_raw();
        cmp("R7 irq_o", {31'h0, irq_o}, {31'h0, |(r & m_en & ~m_route)});
        cmp("R3 fiq_o", {31'h0, fiq_o}, {31'h0, |(r & m_en & m_route)});
    endtask

    // One cycle: drive after the falling edge, check, then let the edge pass.
    task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d,
                         input logic [63:0] s);
        @(negedge clk);
        src_i = s; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        check_outputs();
        if (!we) cmp(tag_of(a), bus_rdata, m_read(a));
    endtask

    task automatic rd(input logic [7:0] a);
        cycle(1'b0, a, 32'h0, src_i);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, src_i);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed0 = $urandom(32'd20240613);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: reset values of every mapped register in both banks
        for (int a = 0; a < 13 * 8; a += 4) rd(8'(a));
        // R10: misaligned and out-of-range reads
        rd(8'h01); rd(8'h6A); rd(8'h68); rd(8'hF8);
        // R1: edge source 3 enabled, rising edge latched
        wr(8'h20, 32'h0000_0008);
        cycle(1'b0, 8'h00, 32'h0, 64'h8);
        rd(8'h60); rd(8'h00);
        // R6: clearing the latch drops the request
        wr(8'h58, 32'h0000_0008);
        rd(8'h60); rd(8'h10);
        // R6: clear on a level source has no effect (bit 16 is level, active high)
        wr(8'h20, 32'h0001_0000);
        cycle(1'b0, 8'h10, 32'h0, 64'h1_0008);
        wr(8'h58, 32'h0001_0000);
        rd(8'h10);
        // R3: route bank 1 bit 8 (source 40) to fast output via soft trigger R2
        wr(8'h1C, 32'h0000_0100);
        wr(8'h24, 32'h0000_0100);
        wr(8'h34, 32'h0000_0100);
        rd(8'h0C); rd(8'h3C);
        wr(8'h3C, 32'h0000_0100);
        rd(8'h0C);
        // R5: falling edge with polarity 0 on source 2, both edges on source 4
        wr(8'h50, 32'hFFFF_FFFB);
        wr(8'h48, 32'h0000_0010);
        wr(8'h20, 32'h0000_0014);
        cycle(1'b0, 8'h60, 32'h0, 64'h14);
        cycle(1'b0, 8'h60, 32'h0, 64'h0);
        rd(8'h60);
        // R4: level source active low with polarity 0
        wr(8'h50, 32'hFFFE_FFFB);
        rd(8'h10);
        // R10: writes to status and unmapped addresses are ignored
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h6C, 32'hFFFF_FFFF); wr(8'h19, 32'hFFFF_FFFF);
        rd(8'h18); rd(8'h10);
        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] s = src_i ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            int op = int'($urandom_range(0, 9));
            logic [7:0] a;
            if (op < 4) begin
                a = 8'({$urandom_range(3, 11), 1'($urandom), 2'b00});
                cycle(1'b1, a, $urandom & $urandom, s);
            end else if (op == 4) begin
                a = 8'($urandom);
                cycle(1'b1, a, $urandom, s);
            end else begin
                a = ($urandom_range(0, 15) == 0) ? 8'($urandom) :
                    8'({$urandom_range(0, 12), 1'($urandom), 2'b00});
                cycle(1'b0, a, 32'h0, s);
            end
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule